// File: doc/BRIEF.md
# Two-Clock Dual-Port Synchronous Word Memory

This block is a 4096-word by 36-bit memory with two independent ports. Each port runs on its own clock and can read or write the shared array at any time. The array is split into four 9-bit lanes, and each lane can be written on its own. Every address, data and control input goes through an input register on the rising edge of its port clock. A read returns data one edge after the command was captured.

Each port has three controls on top of the read and write commands. A stall input freezes the whole port for that edge. A select input deselects the port, and while deselected its output is blank. An output-enable input gates the read bus without waiting for a clock. When one port writes a word that the other port reads in the same cycle, the reader gets the value the word held before the write.

Top module: `dp_sync_ram`

## Requirements
- R1: A word written through either port is returned by a later read of that address from either port. Addresses run from 0 to 4095 and data is 36 bits.
- R2: Write enable bit l selects data bits 9l+8 down to 9l. Lanes whose enable bit is 0 keep their stored contents.
- R3: A read is captured at edge n when select is 1 and all write enables are 0. After edge n+1, rvalid is 1 and rdata holds the word. After edge n, the output still shows the previous command's result.
- R4: If stall is 1 at an edge, that edge has no effect on the port. The input registers are not loaded, the array is not accessed, and rdata/rvalid do not change. The command already held is carried out at the next edge where stall is 0.
- R5: A command captured with select at 0 deselects the port. It writes nothing, and rvalid is 0 after the following edge.
- R6: A command captured with select at 1 and any write enable bit at 1 is a write. It is committed at the next edge, and rvalid is 0 after that edge.
- R7: When oe is 0, rvalid is 0 and rdata is all zeros at once, with no clock edge needed. When oe returns to 1, the registered result shows again.
- R8: A write issued in the cycle right after a read is committed. A read captured in the cycle after a write's capture returns the new data.
- R9: If one port writes an address in the same cycle that the other port reads it, the reader returns the old word. Later reads return the new word.
- R10: While a port's rst_ni is 0, its input registers and rvalid are cleared and its rdata is zero. The array contents are kept.
- R11: Both ports run reads and writes to different addresses in the same cycle without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk_i | input | 1 | Port A clock |
| a_rst_ni | input | 1 | Port A asynchronous reset, active low |
| a_stall_i | input | 1 | Port A stall: freezes the port for that edge |
| a_en_i | input | 1 | Port A select |
| a_we_i | input | 4 | Port A per-lane write enables |
| a_addr_i | input | 12 | Port A word address |
| a_wdata_i | input | 36 | Port A write data |
| a_oe_i | input | 1 | Port A output enable, combinational gate |
| a_rdata_o | output | 36 | Port A read data, zero when not valid |
| a_rvalid_o | output | 1 | Port A read data valid |
| b_clk_i | input | 1 | Port B clock |
| b_rst_ni | input | 1 | Port B asynchronous reset, active low |
| b_stall_i | input | 1 | Port B stall |
| b_en_i | input | 1 | Port B select |
| b_we_i | input | 4 | Port B per-lane write enables |
| b_addr_i | input | 12 | Port B word address |
| b_wdata_i | input | 36 | Port B write data |
| b_oe_i | input | 1 | Port B output enable |
| b_rdata_o | output | 36 | Port B read data |
| b_rvalid_o | output | 1 | Port B read data valid |

## Verification
The assertions check the control pipeline on every cycle:
- A stalled edge leaves the valid flag and the read register unchanged.
- A deselect or a write clears valid at the next edge.
- A captured read raises valid at the next edge.
- The output-enable gate blanks both output buses.

Only the bench scenarios can show that the data is correct: per-lane merging, read-after-write and write-after-read ordering, old data on a cross-port collision, and array contents surviving reset. These depend on what was written earlier, which a single-cycle property cannot follow.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  function automatic op_e decode_op(input logic en, input logic any_we);
    if (!en) return OP_IDLE;
    return any_we ? OP_WRITE : OP_READ;
  endfunction
endpackage

// File: rtl/dpr_port_in.sv
module dpr_port_in
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 36,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              en_i,
  input  logic [LANES-1:0]  we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_q_o,
  output logic [LANES-1:0]  we_q_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] wdata_q_o,
  output op_e               op_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q_o    <= 1'b0;
      we_q_o    <= '0;
      addr_q_o  <= '0;
      wdata_q_o <= '0;
    end else if (!stall_i) begin
      en_q_o    <= en_i;
      we_q_o    <= we_i;
      addr_q_o  <= addr_i;
      wdata_q_o <= wdata_i;
    end
  end

  assign op_o = decode_op(en_q_o, |we_q_o);
endmodule

// File: rtl/dpr_slice.sv
// One lane: each port owns a copy of the data and a tag bit per word.
// The XOR of the two tag bits tells which copy was written last.
module dpr_slice #(
  parameter int ADDR_W = 12,
  parameter int LANE_W = 9
) (
  input  logic              clk_a_i,
  input  logic              wr_a_i,
  input  logic              rd_a_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [LANE_W-1:0] wdata_a_i,
  output logic [LANE_W-1:0] rdata_a_o,
  input  logic              clk_b_i,
  input  logic              wr_b_i,
  input  logic              rd_b_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic [LANE_W-1:0] wdata_b_i,
  output logic [LANE_W-1:0] rdata_b_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_a [DEPTH];
  logic [LANE_W-1:0] mem_b [DEPTH];
  logic [DEPTH-1:0]  tag_a;
  logic [DEPTH-1:0]  tag_b;

  function automatic logic [LANE_W-1:0] fetch(input logic [ADDR_W-1:0] ad);
    return (tag_a[ad] ^ tag_b[ad]) ? mem_b[ad] : mem_a[ad];
  endfunction

  always_ff @(posedge clk_a_i) begin
    if (wr_a_i) begin
      mem_a[addr_a_i] <= wdata_a_i;
      tag_a[addr_a_i] <= tag_b[addr_a_i];   // tags equal: copy A is newest
    end
    if (rd_a_i) rdata_a_o <= fetch(addr_a_i);
  end

  always_ff @(posedge clk_b_i) begin
    if (wr_b_i) begin
      mem_b[addr_b_i] <= wdata_b_i;
      tag_b[addr_b_i] <= ~tag_a[addr_b_i];  // tags differ: copy B is newest
    end
    if (rd_b_i) rdata_b_o <= fetch(addr_b_i);
  end
endmodule

// File: rtl/dpr_port_out.sv
module dpr_port_out
  import dpr_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  op_e               op_i,
  input  logic              oe_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       vld_o <= 1'b0;
    else if (!stall_i) vld_o <= (op_i == OP_READ);
  end

  assign rvalid_o = vld_o & oe_i;
  assign rdata_o  = rvalid_o ? rd_word_i : '0;
endmodule

// File: rtl/dp_sync_ram.sv
module dp_sync_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                      a_clk_i,
  input  logic                      a_rst_ni,
  input  logic                      a_stall_i,
  input  logic                      a_en_i,
  input  logic [LANES-1:0]          a_we_i,
  input  logic [ADDR_W-1:0]         a_addr_i,
  input  logic [LANE_W*LANES-1:0]   a_wdata_i,
  input  logic                      a_oe_i,
  output logic [LANE_W*LANES-1:0]   a_rdata_o,
  output logic                      a_rvalid_o,
  input  logic                      b_clk_i,
  input  logic                      b_rst_ni,
  input  logic                      b_stall_i,
  input  logic                      b_en_i,
  input  logic [LANES-1:0]          b_we_i,
  input  logic [ADDR_W-1:0]         b_addr_i,
  input  logic [LANE_W*LANES-1:0]   b_wdata_i,
  input  logic                      b_oe_i,
  output logic [LANE_W*LANES-1:0]   b_rdata_o,
  output logic                      b_rvalid_o
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int NPORT  = 2;

  logic              clk_w      [NPORT];
  logic              rst_n_w    [NPORT];
  logic              stall_w    [NPORT];
  logic              en_w       [NPORT];
  logic [LANES-1:0]  we_w       [NPORT];
  logic [ADDR_W-1:0] addr_w     [NPORT];
  logic [DATA_W-1:0] wdata_w    [NPORT];
  logic              oe_w       [NPORT];
  logic              en_q_w     [NPORT];
  logic [LANES-1:0]  we_q_w     [NPORT];
  logic [ADDR_W-1:0] addr_q_w   [NPORT];
  logic [DATA_W-1:0] wdata_q_w  [NPORT];
  op_e               op_w       [NPORT];
  logic              wr_w       [NPORT];
  logic              rd_w       [NPORT];
  logic [DATA_W-1:0] rd_word_w  [NPORT];
  logic [DATA_W-1:0] rdata_w    [NPORT];
  logic              rvalid_w   [NPORT];
  logic              vld_w      [NPORT];
  logic [DATA_W-1:0] rd_a_word, rd_b_word;

  assign clk_w[0]   = a_clk_i;   assign clk_w[1]   = b_clk_i;
  assign rst_n_w[0] = a_rst_ni;  assign rst_n_w[1] = b_rst_ni;
  assign stall_w[0] = a_stall_i; assign stall_w[1] = b_stall_i;
  assign en_w[0]    = a_en_i;    assign en_w[1]    = b_en_i;
  assign we_w[0]    = a_we_i;    assign we_w[1]    = b_we_i;
  assign addr_w[0]  = a_addr_i;  assign addr_w[1]  = b_addr_i;
  assign wdata_w[0] = a_wdata_i; assign wdata_w[1] = b_wdata_i;
  assign oe_w[0]    = a_oe_i;    assign oe_w[1]    = b_oe_i;
  assign rd_word_w[0] = rd_a_word;
  assign rd_word_w[1] = rd_b_word;
  assign a_rdata_o  = rdata_w[0];  assign a_rvalid_o = rvalid_w[0];
  assign b_rdata_o  = rdata_w[1];  assign b_rvalid_o = rvalid_w[1];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpr_port_in #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_in (
      .clk_i     (clk_w[p]),
      .rst_ni    (rst_n_w[p]),
      .stall_i   (stall_w[p]),
      .en_i      (en_w[p]),
      .we_i      (we_w[p]),
      .addr_i    (addr_w[p]),
      .wdata_i   (wdata_w[p]),
      .en_q_o    (en_q_w[p]),
      .we_q_o    (we_q_w[p]),
      .addr_q_o  (addr_q_w[p]),
      .wdata_q_o (wdata_q_w[p]),
      .op_o      (op_w[p])
    );

    // a stalled edge must not touch the array
    assign wr_w[p] = !stall_w[p] && (op_w[p] == OP_WRITE);
    assign rd_w[p] = !stall_w[p] && (op_w[p] == OP_READ);

    dpr_port_out #(.DATA_W(DATA_W)) u_out (
      .clk_i     (clk_w[p]),
      .rst_ni    (rst_n_w[p]),
      .stall_i   (stall_w[p]),
      .op_i      (op_w[p]),
      .oe_i      (oe_w[p]),
      .rd_word_i (rd_word_w[p]),
      .rdata_o   (rdata_w[p]),
      .rvalid_o  (rvalid_w[p]),
      .vld_o     (vld_w[p])
    );
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dpr_slice #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_slice (
      .clk_a_i   (a_clk_i),
      .wr_a_i    (wr_w[0] & we_q_w[0][l]),
      .rd_a_i    (rd_w[0]),
      .addr_a_i  (addr_q_w[0]),
      .wdata_a_i (wdata_q_w[0][l*LANE_W +: LANE_W]),
      .rdata_a_o (rd_a_word[l*LANE_W +: LANE_W]),
      .clk_b_i   (b_clk_i),
      .wr_b_i    (wr_w[1] & we_q_w[1][l]),
      .rd_b_i    (rd_w[1]),
      .addr_b_i  (addr_q_w[1]),
      .wdata_b_i (wdata_q_w[1][l*LANE_W +: LANE_W]),
      .rdata_b_o (rd_b_word[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/dp_sync_ram_chk.sv
module dp_sync_ram_chk #(
  parameter int DATA_W = 36,
  parameter int LANES  = 4
) (
  input logic              a_clk_i,
  input logic              b_clk_i,
  input logic              a_rst_ni,
  input logic              b_rst_ni,
  input logic              a_stall_i,
  input logic              b_stall_i,
  input logic              a_oe_i,
  input logic              b_oe_i,
  input logic              a_rvalid_o,
  input logic              b_rvalid_o,
  input logic [DATA_W-1:0] a_rdata_o,
  input logic [DATA_W-1:0] b_rdata_o,
  input logic              a_en_q,
  input logic              b_en_q,
  input logic [LANES-1:0]  a_we_q,
  input logic [LANES-1:0]  b_we_q,
  input logic              a_vld,
  input logic              b_vld,
  input logic [DATA_W-1:0] a_rd_word,
  input logic [DATA_W-1:0] b_rd_word
);
  logic              clk   [2];
  logic              rst_n [2];
  logic              stall [2];
  logic              oe    [2];
  logic              rv    [2];
  logic [DATA_W-1:0] rdat  [2];
  logic              en_q  [2];
  logic [LANES-1:0]  we_q  [2];
  logic              vld   [2];
  logic [DATA_W-1:0] word  [2];

  assign clk[0] = a_clk_i;      assign clk[1] = b_clk_i;
  assign rst_n[0] = a_rst_ni;   assign rst_n[1] = b_rst_ni;
  assign stall[0] = a_stall_i;  assign stall[1] = b_stall_i;
  assign oe[0] = a_oe_i;        assign oe[1] = b_oe_i;
  assign rv[0] = a_rvalid_o;    assign rv[1] = b_rvalid_o;
  assign rdat[0] = a_rdata_o;   assign rdat[1] = b_rdata_o;
  assign en_q[0] = a_en_q;      assign en_q[1] = b_en_q;
  assign we_q[0] = a_we_q;      assign we_q[1] = b_we_q;
  assign vld[0] = a_vld;        assign vld[1] = b_vld;
  assign word[0] = a_rd_word;   assign word[1] = b_rd_word;

  for (genvar p = 0; p < 2; p++) begin : g_chk
    AST_STALL_FREEZES: assert property (@(posedge clk[p]) disable iff (!rst_n[p])
      stall[p] |=> ($stable(vld[p]) && $stable(word[p])));  // R4

    AST_DESELECT_BLANKS: assert property (@(posedge clk[p]) disable iff (!rst_n[p])
      (!stall[p] && !en_q[p]) |=> !vld[p]);  // R5

    AST_WRITE_BLANKS: assert property (@(posedge clk[p]) disable iff (!rst_n[p])
      (!stall[p] && en_q[p] && (|we_q[p])) |=> !vld[p]);  // R6

    AST_READ_VALID: assert property (@(posedge clk[p]) disable iff (!rst_n[p])
      (!stall[p] && en_q[p] && !(|we_q[p])) |=> vld[p]);  // R3

    always_comb begin
      if (rst_n[p] && !oe[p]) begin
        AST_OE_BLANKS: assert (!rv[p] && (rdat[p] == '0));  // R7
      end
    end
  end
endmodule

bind dp_sync_ram dp_sync_ram_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
  .a_clk_i    (a_clk_i),
  .b_clk_i    (b_clk_i),
  .a_rst_ni   (a_rst_ni),
  .b_rst_ni   (b_rst_ni),
  .a_stall_i  (a_stall_i),
  .b_stall_i  (b_stall_i),
  .a_oe_i     (a_oe_i),
  .b_oe_i     (b_oe_i),
  .a_rvalid_o (a_rvalid_o),
  .b_rvalid_o (b_rvalid_o),
  .a_rdata_o  (a_rdata_o),
  .b_rdata_o  (b_rdata_o),
  .a_en_q     (en_q_w[0]),
  .b_en_q     (en_q_w[1]),
  .a_we_q     (we_q_w[0]),
  .b_we_q     (we_q_w[1]),
  .a_vld      (vld_w[0]),
  .b_vld      (vld_w[1]),
  .a_rd_word  (rd_a_word),
  .b_rd_word  (rd_b_word)
);

// File: tb/dp_sync_ram_tb.sv
module dp_sync_ram_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall [2];
  logic        en    [2];
  logic [3:0]  we    [2];
  logic [11:0] addr  [2];
  logic [35:0] wd    [2];
  logic        oe    [2];
  logic [35:0] rdata [2];
  logic        rvalid[2];

  logic [35:0] model [4096];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dp_sync_ram u_dut (
    .a_clk_i(clk), .a_rst_ni(rst_n), .a_stall_i(stall[0]), .a_en_i(en[0]),
    .a_we_i(we[0]), .a_addr_i(addr[0]), .a_wdata_i(wd[0]), .a_oe_i(oe[0]),
    .a_rdata_o(rdata[0]), .a_rvalid_o(rvalid[0]),
    .b_clk_i(clk), .b_rst_ni(rst_n), .b_stall_i(stall[1]), .b_en_i(en[1]),
    .b_we_i(we[1]), .b_addr_i(addr[1]), .b_wdata_i(wd[1]), .b_oe_i(oe[1]),
    .b_rdata_o(rdata[1]), .b_rvalid_o(rvalid[1])
  );

  function automatic logic [35:0] merge(logic [35:0] old, logic [3:0] w, logic [35:0] d);
    logic [35:0] r = old;
    for (int l = 0; l < 4; l++) if (w[l]) r[l*9 +: 9] = d[l*9 +: 9];
    return r;
  endfunction

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drv(int p, logic e, logic [3:0] w, logic [11:0] ad, logic [35:0] d);
    en[p] = e; we[p] = w; addr[p] = ad; wd[p] = d;
  endtask

  task automatic idle_all();
    drv(0, 0, 4'h0, 12'h0, 36'h0);
    drv(1, 0, 4'h0, 12'h0, 36'h0);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(int p, logic [11:0] ad, logic [3:0] w, logic [35:0] d);
    drv(p, 1, w, ad, d); tick(); idle_all(); tick();
    model[ad] = merge(model[ad], w, d);
  endtask

  task automatic rd_chk(int p, logic [11:0] ad, string req);
    drv(p, 1, 4'h0, ad, 36'h0); tick(); idle_all(); tick();
    chk(req, {35'h0, rvalid[p]}, 36'h1);
    chk(req, rdata[p], model[ad]);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [35:0] d, ea, eb;
    void'($urandom(32'd7351));
    rst_n = 0;
    for (int p = 0; p < 2; p++) begin stall[p] = 0; oe[p] = 1; end
    idle_all();
    repeat (3) tick();
    // R10: reset state
    chk("R10 reset rvalid A", {35'h0, rvalid[0]}, 36'h0);
    chk("R10 reset rdata B", rdata[1], 36'h0);
    rst_n = 1;
    tick();

    // R1: fill through port A, read back on B
    for (int i = 0; i < 66; i++) begin
      logic [11:0] ad = (i < 64) ? 12'(i) : 12'(4094 + i - 64);
      wr(0, ad, 4'hF, {$urandom, $urandom} & 36'hF_FFFF_FFFF);
    end
    rd_chk(1, 12'd4095, "R1 top address via B");
    rd_chk(1, 12'd0, "R1 address zero via B");
    wr(1, 12'd5, 4'hF, 36'h1_2345_6789);
    rd_chk(0, 12'd5, "R1 B write read on A");

    // R2: lane write
    wr(0, 12'd7, 4'hF, 36'hF_FFFF_FFFF);
    wr(1, 12'd7, 4'b0101, 36'h0_0000_0000);
    rd_chk(0, 12'd7, "R2 lanes 0 and 2 only");
    chk("R2 lane pattern", model[7], 36'hF_F803_FE00);

    // R3: latency
    drv(0, 1, 4'h0, 12'd3, 36'h0); tick();
    chk("R3 not valid after capture edge", {35'h0, rvalid[0]}, 36'h0);
    idle_all(); tick();
    chk("R3 valid after next edge", {35'h0, rvalid[0]}, 36'h1);
    chk("R3 data after next edge", rdata[0], model[3]);

    // R4: stall holds outputs and drops stalled inputs
    drv(0, 1, 4'h0, 12'd9, 36'h0); tick();
    stall[0] = 1; drv(0, 1, 4'hF, 12'd9, 36'hA_AAAA_AAAA); tick();
    chk("R4 stalled edge output held", {35'h0, rvalid[0]}, 36'h0);
    stall[0] = 0; idle_all(); tick();
    chk("R4 held read runs after stall", {35'h0, rvalid[0]}, 36'h1);
    chk("R4 held read data", rdata[0], model[9]);
    stall[0] = 1; tick();
    chk("R4 valid kept across stall", {35'h0, rvalid[0]}, 36'h1);
    chk("R4 data kept across stall", rdata[0], model[9]);
    stall[0] = 0; tick();
    rd_chk(1, 12'd9, "R4 stalled write ignored");

    // R5: deselect
    drv(0, 0, 4'hF, 12'd11, 36'h5_5555_5555); tick(); idle_all(); tick();
    chk("R5 deselect no valid", {35'h0, rvalid[0]}, 36'h0);
    rd_chk(0, 12'd11, "R5 deselect no write");

    // R6 and R7
    rd_chk(0, 12'd12, "R6 setup read");
    drv(0, 1, 4'h3, 12'd12, 36'h0_0000_0ABC); tick(); idle_all(); tick();
    model[12] = merge(model[12], 4'h3, 36'h0_0000_0ABC);
    chk("R6 write clears valid", {35'h0, rvalid[0]}, 36'h0);
    rd_chk(0, 12'd12, "R6 write committed");
    oe[0] = 0; #1;
    chk("R7 oe low rvalid", {35'h0, rvalid[0]}, 36'h0);
    chk("R7 oe low rdata", rdata[0], 36'h0);
    oe[0] = 1; #1;
    chk("R7 oe high restores", rdata[0], model[12]);
    tick();

    // R8: back-to-back
    d = 36'h3_1415_9265;
    drv(0, 1, 4'hF, 12'd20, d); tick();
    drv(0, 1, 4'h0, 12'd20, 36'h0); tick();
    model[20] = d; idle_all(); tick();
    chk("R8 read after write new data", rdata[0], d);
    ea = model[21];
    drv(0, 1, 4'h0, 12'd21, 36'h0); tick();
    drv(0, 1, 4'hF, 12'd21, 36'h2_7182_8182); tick();
    chk("R8 read before write old data", rdata[0], ea);
    idle_all(); tick();
    model[21] = 36'h2_7182_8182;
    rd_chk(1, 12'd21, "R8 write after read committed");

    // R9: collision
    ea = model[30];
    drv(0, 1, 4'hF, 12'd30, 36'h9_8765_4321);
    drv(1, 1, 4'h0, 12'd30, 36'h0); tick(); idle_all(); tick();
    chk("R9 collision returns old", rdata[1], ea);
    model[30] = 36'h9_8765_4321;
    rd_chk(1, 12'd30, "R9 next read returns new");

    // R10: reset keeps array
    rd_chk(0, 12'd30, "R10 setup read");
    rst_n = 0; #1;
    chk("R10 reset clears valid", {35'h0, rvalid[0]}, 36'h0);
    tick(); rst_n = 1; tick();
    rd_chk(0, 12'd30, "R10 array retained");

    // R11: random concurrent traffic
    for (int it = 0; it < 400; it++) begin
      int ka, kb;
      logic [11:0] aa, ab;
      logic [3:0] wa, wb;
      logic [35:0] da, db;
      ka = $urandom % 3; kb = $urandom % 3;
      aa = ($urandom % 66 < 64) ? 12'($urandom % 64) : 12'd4095;
      ab = ($urandom % 66 < 64) ? 12'($urandom % 64) : 12'd4094;
      wa = 4'($urandom % 15 + 1); wb = 4'($urandom % 15 + 1);
      da = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
      db = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
      if (ka == 2 && kb == 2 && aa == ab) kb = 1;
      drv(0, ka != 0, (ka == 2) ? wa : 4'h0, aa, da);
      drv(1, kb != 0, (kb == 2) ? wb : 4'h0, ab, db);
      ea = model[aa]; eb = model[ab];
      tick(); idle_all(); tick();
      chk("R11 port A valid", {35'h0, rvalid[0]}, {35'h0, ka == 1});
      chk("R11 port B valid", {35'h0, rvalid[1]}, {35'h0, kb == 1});
      if (ka == 1) chk("R11 port A data", rdata[0], ea);
      if (kb == 1) chk("R11 port B data", rdata[1], eb);
      if (ka == 2) model[aa] = merge(model[aa], wa, da);
      if (kb == 2) model[ab] = merge(model[ab], wb, db);
    end
    done = 1;
    summary();
  end
endmodule